// File: doc/BRIEF.md
# System Segment Register Loader

This block carries out the two privileged operations that point the processor at a local descriptor table or at a task state segment. A request gives a 16-bit selector, the current privilege level, a protected-mode flag and which of the two registers to load. The block screens the selector first. When the selector passes the screen, the block fetches the 8-byte descriptor from the global table as two 32-bit reads over a simple memory port. It then judges the descriptor type and present bit. If all checks pass, it writes the selector and the descriptor into the chosen register's cache and sets the cache's valid bit.

A task-register load also marks the task segment busy. The busy flag is set in the cached copy, and the upper descriptor word is written back to the table with the flag set. Every outcome is reported on `fault_kind` together with a 16-bit error code. A fault leaves both register caches untouched.

The controller has five states. IDLE accepts `start`. From IDLE it goes to FETCH_LO when the screen passes, or straight to REPORT when the screen faults or the selector is a null LDT selector. FETCH_LO moves to FETCH_HI on `mem_ack`. FETCH_HI moves on `mem_ack` to one of two states: MARK_BUSY when a task segment needs its busy flag written back, or REPORT in every other case. MARK_BUSY moves to REPORT on `mem_ack`. REPORT returns to IDLE after one cycle.

Top module: `seg_reg_loader`

## Requirements
- R1: With `prot_en` low, the request ends with `fault_kind`=1 (invalid opcode) and `fault_err`=0, without any memory access. The fault encoding is 0 none, 1 invalid opcode, 2 general protection, 3 not present.
- R2: With `cpl` not zero (and `prot_en` high), the request ends with `fault_kind`=2 and `fault_err`=0, without any memory access.
- R3: An LDT load (`target`=0) whose selector has bits 15:2 all zero raises no fault and makes no memory access. It stores the whole selector in `ldt_sel` and clears `ldt_valid`.
- R4: A task-register load (`target`=1) with bits 15:2 of the selector all zero ends with `fault_kind`=2 and `fault_err`=0.
- R5: A non-null selector with bit 2 set ends with `fault_kind`=2 and `fault_err` = selector AND 0xFFFC, without any memory access.
- R6: A selector whose descriptor end, (bits 15:3)×8+7, is greater than `table_limit` ends with `fault_kind`=2 and the masked selector, without any memory access. A descriptor end equal to the limit is accepted.
- R7: A descriptor is fetched as two reads: first at `table_base` + index×8, then at that address + 4. A request holds `mem_req`, `mem_we` and `mem_addr` steady until the cycle in which `mem_ack` is high.
- R8: An LDT load accepts only a descriptor with upper-word bit 12 clear and type (bits 11:8) equal to 2. Any other descriptor gives `fault_kind`=2 with the masked selector.
- R9: A task-register load accepts only upper-word bit 12 clear with type 1 or 9 (available task segments). Any other descriptor, busy types included, gives `fault_kind`=2 with the masked selector.
- R10: A descriptor of an accepted type whose upper-word bit 15 (present) is clear gives `fault_kind`=3 with the masked selector.
- R11: A successful LDT load sets `ldt_sel` to the selector, `ldt_lo` and `ldt_hi` to the two descriptor words, and `ldt_valid` to 1.
- R12: A successful task-register load sets `tr_sel`, `tr_lo` and `tr_valid`, and sets `tr_hi` to the upper word with bit 9 set. When bit 9 was clear in the table, it then writes the upper word with bit 9 set to `table_base` + index×8 + 4.
- R13: Every faulting request leaves all outputs of both register caches unchanged.
- R14: `done` is high for exactly one cycle per request. `fault_kind` and `fault_err` stay valid from that cycle until the next `start`. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a request (sampled in IDLE) |
| target | input | 1 | 0 = load LDT register, 1 = load task register |
| selector | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protected mode active |
| table_base | input | ADDR_W | Global descriptor table base address |
| table_limit | input | LIMIT_W | Global descriptor table limit (last valid byte) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_kind | output | 2 | 0 none, 1 invalid opcode, 2 general protection, 3 not present |
| fault_err | output | 16 | Error code of the fault |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Read data |
| ldt_sel | output | 16 | LDT register selector |
| ldt_lo | output | 32 | LDT cached descriptor, lower word |
| ldt_hi | output | 32 | LDT cached descriptor, upper word |
| ldt_valid | output | 1 | LDT cache valid |
| tr_sel | output | 16 | Task register selector |
| tr_lo | output | 32 | Task register cached descriptor, lower word |
| tr_hi | output | 32 | Task register cached descriptor, upper word |
| tr_valid | output | 1 | Task register cache valid |

## Verification
The bench builds the block with ADDR_W=32 and LIMIT_W=16, and attaches a 16-entry descriptor table based at 0x2000 that answers after a random delay of 0 to 2 cycles. With a 16-bit limit, the bench can drive descriptor ends both equal to and one past the limit. Selectors reach every table slot. The random delay exercises the hold-until-acknowledged rule on all three kinds of access. Because the write-back lands in the bench's table, a second load of the same task segment meets the busy type and must be refused.

// File: rtl/seg_ld_pkg.sv
`timescale 1ns/1ps
package seg_ld_pkg;
    localparam int SEL_W       = 16;
    localparam int DESC_W      = 32;
    localparam int BUSY_BIT    = 9;
    localparam int PRESENT_BIT = 15;
    localparam int SFLAG_BIT   = 12;
    localparam logic [3:0] TY_LDT   = 4'h2;
    localparam logic [3:0] TY_TSS16 = 4'h1;
    localparam logic [3:0] TY_TSS32 = 4'h9;
    localparam logic [SEL_W-1:0] ERR_MASK = 16'hFFFC;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_GP   = 2'd2,
        FLT_NP   = 2'd3
    } fault_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_MARK_BUSY,
        ST_REPORT
    } ld_state_t;

    typedef enum logic {
        TGT_LDT = 1'b0,
        TGT_TR  = 1'b1
    } tgt_t;
endpackage

// File: rtl/sel_screen.sv
`timescale 1ns/1ps
module sel_screen
    import seg_ld_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               prot_en,
    input  logic [1:0]         cpl,
    input  logic               target,
    input  logic [SEL_W-1:0]   selector,
    input  logic [LIMIT_W-1:0] table_limit,
    output fault_t             scr_fault,
    output logic [SEL_W-1:0]   scr_err,
    output logic               null_ldt,
    output logic               fetch_ok
);
    localparam int CMP_W = ((LIMIT_W > SEL_W) ? LIMIT_W : SEL_W) + 1;

    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] lim_ext;
    logic             is_null;

    assign last_byte = CMP_W'({selector[SEL_W-1:3], 3'b111});
    assign lim_ext   = CMP_W'(table_limit);
    assign is_null   = (selector[SEL_W-1:2] == '0);

    // Order of the screen is the priority of the faults.
    always_comb begin
        scr_fault = FLT_NONE;
        scr_err   = '0;
        null_ldt  = 1'b0;
        fetch_ok  = 1'b0;
        if (!prot_en) begin
            scr_fault = FLT_UD;
        end else if (cpl != 2'd0) begin
            scr_fault = FLT_GP;
        end else if (is_null) begin
            if (target == TGT_LDT) begin
                null_ldt = 1'b1;
            end else begin
                scr_fault = FLT_GP;
            end
        end else if (selector[2]) begin
            scr_fault = FLT_GP;
            scr_err   = selector & ERR_MASK;
        end else if (last_byte > lim_ext) begin
            scr_fault = FLT_GP;
            scr_err   = selector & ERR_MASK;
        end else begin
            fetch_ok = 1'b1;
        end
    end
endmodule

// File: rtl/desc_judge.sv
`timescale 1ns/1ps
module desc_judge
    import seg_ld_pkg::*;
(
    input  logic              target,
    input  logic [DESC_W-1:0] desc_hi,
    output fault_t            jdg_fault,
    output logic [DESC_W-1:0] cache_hi,
    output logic              need_mark
);
    logic       is_system;
    logic [3:0] dtype;
    logic       type_ok;

    assign is_system = !desc_hi[SFLAG_BIT];
    assign dtype     = desc_hi[11:8];

    always_comb begin
        if (target == TGT_LDT) begin
            type_ok = is_system && (dtype == TY_LDT);
        end else begin
            type_ok = is_system && ((dtype == TY_TSS16) || (dtype == TY_TSS32));
        end
    end

    always_comb begin
        if (!type_ok) begin
            jdg_fault = FLT_GP;
        end else if (!desc_hi[PRESENT_BIT]) begin
            jdg_fault = FLT_NP;
        end else begin
            jdg_fault = FLT_NONE;
        end
    end

    always_comb begin
        cache_hi  = desc_hi;
        need_mark = 1'b0;
        if (target == TGT_TR) begin
            cache_hi[BUSY_BIT] = 1'b1;
            need_mark          = !desc_hi[BUSY_BIT];
        end
    end
endmodule

// File: rtl/sys_seg_cache.sv
`timescale 1ns/1ps
module sys_seg_cache
    import seg_ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              inval_en,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [DESC_W-1:0] lo_in,
    input  logic [DESC_W-1:0] hi_in,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DESC_W-1:0] lo_q,
    output logic [DESC_W-1:0] hi_q,
    output logic              valid_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            valid_q <= 1'b0;
        end else if (load_en) begin
            sel_q   <= sel_in;
            lo_q    <= lo_in;
            hi_q    <= hi_in;
            valid_q <= 1'b1;
        end else if (inval_en) begin
            sel_q   <= sel_in;
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/seg_reg_loader.sv
`timescale 1ns/1ps
module seg_reg_loader
    import seg_ld_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               target,
    input  logic [15:0]        selector,
    input  logic [1:0]         cpl,
    input  logic               prot_en,
    input  logic [ADDR_W-1:0]  table_base,
    input  logic [LIMIT_W-1:0] table_limit,
    output logic               busy,
    output logic               done,
    output logic [1:0]         fault_kind,
    output logic [15:0]        fault_err,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic [15:0]        ldt_sel,
    output logic [31:0]        ldt_lo,
    output logic [31:0]        ldt_hi,
    output logic               ldt_valid,
    output logic [15:0]        tr_sel,
    output logic [31:0]        tr_lo,
    output logic [31:0]        tr_hi,
    output logic               tr_valid
);
    localparam int NUM_TGT   = 2;
    localparam int HI_OFS    = DESC_W / 8;
    localparam int IDX_SHIFT = 3;

    ld_state_t          state_q, state_d;
    logic               tgt_q;
    logic [SEL_W-1:0]   sel_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DESC_W-1:0]  lo_q;
    logic [DESC_W-1:0]  hi_q;
    fault_t             fault_q;
    logic [SEL_W-1:0]   err_q;
    logic [ADDR_W-1:0]  desc_addr;

    fault_t             scr_fault;
    logic [SEL_W-1:0]   scr_err;
    logic               null_ldt;
    logic               fetch_ok;

    fault_t             jdg_fault;
    logic [DESC_W-1:0]  jdg_hi;
    logic               need_mark;

    logic [NUM_TGT-1:0] load_en;
    logic [NUM_TGT-1:0] inval_en;
    logic [SEL_W-1:0]   cache_sel_in;
    logic [SEL_W-1:0]   c_sel   [NUM_TGT];
    logic [DESC_W-1:0]  c_lo    [NUM_TGT];
    logic [DESC_W-1:0]  c_hi    [NUM_TGT];
    logic               c_valid [NUM_TGT];

    logic take_start, lo_ack, hi_ack, mark_ack;

    assign desc_addr = table_base + ADDR_W'({selector[SEL_W-1:IDX_SHIFT], 3'b000});

    sel_screen #(.LIMIT_W(LIMIT_W)) u_screen (
        .prot_en    (prot_en),
        .cpl        (cpl),
        .target     (target),
        .selector   (selector),
        .table_limit(table_limit),
        .scr_fault  (scr_fault),
        .scr_err    (scr_err),
        .null_ldt   (null_ldt),
        .fetch_ok   (fetch_ok)
    );

    desc_judge u_judge (
        .target   (tgt_q),
        .desc_hi  (mem_rdata),
        .jdg_fault(jdg_fault),
        .cache_hi (jdg_hi),
        .need_mark(need_mark)
    );

    assign take_start = (state_q == ST_IDLE) && start;
    assign lo_ack     = (state_q == ST_FETCH_LO) && mem_ack;
    assign hi_ack     = (state_q == ST_FETCH_HI) && mem_ack;
    assign mark_ack   = (state_q == ST_MARK_BUSY) && mem_ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = fetch_ok ? ST_FETCH_LO : ST_REPORT;
                end
            end
            ST_FETCH_LO: begin
                if (mem_ack) state_d = ST_FETCH_HI;
            end
            ST_FETCH_HI: begin
                if (mem_ack) begin
                    if (jdg_fault == FLT_NONE && need_mark) begin
                        state_d = ST_MARK_BUSY;
                    end else begin
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_MARK_BUSY: begin
                if (mem_ack) state_d = ST_REPORT;
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = addr_q;
        mem_wdata    = '0;
        done         = 1'b0;
        busy         = (state_q != ST_IDLE);
        load_en      = '0;
        inval_en     = '0;
        cache_sel_in = sel_q;
        unique case (state_q)
            ST_IDLE: begin
                cache_sel_in = selector;
                inval_en[TGT_LDT] = start && null_ldt;
            end
            ST_FETCH_LO: begin
                mem_req = 1'b1;
            end
            ST_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = addr_q + ADDR_W'(HI_OFS);
                if (mem_ack && jdg_fault == FLT_NONE) begin
                    load_en[tgt_q] = 1'b1;
                end
            end
            ST_MARK_BUSY: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_q + ADDR_W'(HI_OFS);
                mem_wdata = hi_q;
            end
            ST_REPORT: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // Request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= 1'b0;
            sel_q   <= '0;
            addr_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            fault_q <= FLT_NONE;
            err_q   <= '0;
        end else if (take_start) begin
            tgt_q   <= target;
            sel_q   <= selector;
            addr_q  <= desc_addr;
            fault_q <= scr_fault;
            err_q   <= scr_err;
        end else if (lo_ack) begin
            lo_q <= mem_rdata;
        end else if (hi_ack) begin
            hi_q <= jdg_hi;
            if (jdg_fault != FLT_NONE) begin
                fault_q <= jdg_fault;
                err_q   <= sel_q & ERR_MASK;
            end
        end
    end

    assign fault_kind = fault_q;
    assign fault_err  = err_q;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_cache
        sys_seg_cache u_cache (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (load_en[g]),
            .inval_en(inval_en[g]),
            .sel_in  (cache_sel_in),
            .lo_in   (lo_q),
            .hi_in   (jdg_hi),
            .sel_q   (c_sel[g]),
            .lo_q    (c_lo[g]),
            .hi_q    (c_hi[g]),
            .valid_q (c_valid[g])
        );
    end

    assign ldt_sel   = c_sel[TGT_LDT];
    assign ldt_lo    = c_lo[TGT_LDT];
    assign ldt_hi    = c_hi[TGT_LDT];
    assign ldt_valid = c_valid[TGT_LDT];
    assign tr_sel    = c_sel[TGT_TR];
    assign tr_lo     = c_lo[TGT_TR];
    assign tr_hi     = c_hi[TGT_TR];
    assign tr_valid  = c_valid[TGT_TR];

    // Assertions
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_hi_follows_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && (state_q == ST_FETCH_LO)
        |=> mem_req && !mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(HI_OFS)));

    p_mark_sets_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BUSY_BIT]);

    p_tr_valid_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tr_valid) |-> tr_hi[BUSY_BIT]);

    p_done_single_r14: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fault_keeps_cache_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fault_kind != 2'd0)
        |-> $stable(ldt_valid) && $stable(tr_valid) && $stable(ldt_sel) && $stable(tr_sel)
            && $stable(ldt_hi) && $stable(tr_hi));

    p_ud_zero_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fault_kind == 2'd1) |-> (fault_err == 16'd0));

    p_null_ldt_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fault_kind == 2'd0) && (ldt_sel[15:2] == 14'd0) && (tgt_q == TGT_LDT)
        |-> !ldt_valid);
endmodule

// File: tb/seg_reg_loader_tb.sv
`timescale 1ns/1ps
module seg_reg_loader_tb;
    localparam int ADDR_W  = 32;
    localparam int LIMIT_W = 16;
    localparam int NDESC   = 16;
    localparam logic [31:0] TBASE   = 32'h0000_2000;
    localparam logic [15:0] FULLLIM = 16'(NDESC * 8 - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, target = 1'b0, prot_en = 1'b0;
    logic [15:0] selector = '0;
    logic [1:0] cpl = '0;
    logic [ADDR_W-1:0] table_base = TBASE;
    logic [LIMIT_W-1:0] table_limit = FULLLIM;
    logic busy, done, mem_req, mem_we;
    logic [1:0] fault_kind;
    logic [15:0] fault_err;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] ldt_sel, tr_sel;
    logic [31:0] ldt_lo, ldt_hi, tr_lo, tr_hi;
    logic ldt_valid, tr_valid;

    always #2.5 clk = ~clk;

    seg_reg_loader #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target), .selector(selector),
        .cpl(cpl), .prot_en(prot_en), .table_base(table_base), .table_limit(table_limit),
        .busy(busy), .done(done), .fault_kind(fault_kind), .fault_err(fault_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ldt_sel(ldt_sel), .ldt_lo(ldt_lo), .ldt_hi(ldt_hi), .ldt_valid(ldt_valid),
        .tr_sel(tr_sel), .tr_lo(tr_lo), .tr_hi(tr_hi), .tr_valid(tr_valid)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Descriptor table and access log
    logic [31:0] dmem [0:2*NDESC-1];
    int          log_n = 0;
    logic [31:0] log_addr [0:7];
    logic        log_we   [0:7];
    bit          pend = 0;
    int          wl = 0;

    always @(negedge clk) begin
        int widx;
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            if (!pend) begin
                pend = 1;
                wl = $urandom_range(2, 0);
            end
            if (wl == 0) begin
                widx = int'((mem_addr - TBASE) >> 2);
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                end
                log_n++;
                if (widx >= 0 && widx < 2 * NDESC) begin
                    if (mem_we) dmem[widx] = mem_wdata;
                    mem_rdata = dmem[widx];
                end else begin
                    mem_rdata = '0;
                end
                mem_ack = 1'b1;
                pend = 0;
            end else begin
                wl--;
            end
        end else begin
            pend = 0;
        end
    end

    // Expected state
    logic [15:0] e_ldt_sel = '0, e_tr_sel = '0;
    logic [31:0] e_ldt_lo = '0, e_ldt_hi = '0, e_tr_lo = '0, e_tr_hi = '0;
    logic        e_ldt_v = 0, e_tr_v = 0;
    logic [1:0]  e_fk;
    logic [15:0] e_err;
    int          e_nacc;
    logic [31:0] e_addr [0:2];
    logic        e_we   [0:2];
    int          e_wb_idx;
    logic [31:0] e_wb_data;
    string       e_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(input bit p, input logic [1:0] c, input bit t,
                         input logic [15:0] s, input logic [15:0] lim);
        logic [31:0] a, lo, hi;
        int idx;
        bit tok;
        e_fk = 2'd0; e_err = 16'd0; e_nacc = 0;
        if (!p) begin
            e_fk = 2'd1; e_tag = "R1";
        end else if (c != 2'd0) begin
            e_fk = 2'd2; e_tag = "R2";
        end else if (s[15:2] == 14'd0) begin
            if (!t) begin
                e_ldt_sel = s; e_ldt_v = 0; e_tag = "R3";
            end else begin
                e_fk = 2'd2; e_tag = "R4";
            end
        end else if (s[2]) begin
            e_fk = 2'd2; e_err = s & 16'hFFFC; e_tag = "R5";
        end else if ({1'b0, s[15:3], 3'b111} > {1'b0, lim}) begin
            e_fk = 2'd2; e_err = s & 16'hFFFC; e_tag = "R6";
        end else begin
            idx = int'(s[15:3]);
            a = TBASE + 32'(idx * 8);
            lo = dmem[2*idx];
            hi = dmem[2*idx+1];
            e_nacc = 2;
            e_addr[0] = a;     e_we[0] = 0;
            e_addr[1] = a + 4; e_we[1] = 0;
            if (!t) tok = !hi[12] && (hi[11:8] == 4'h2);
            else    tok = !hi[12] && (hi[11:8] == 4'h1 || hi[11:8] == 4'h9);
            if (!tok) begin
                e_fk = 2'd2; e_err = s & 16'hFFFC; e_tag = t ? "R9" : "R8";
            end else if (!hi[15]) begin
                e_fk = 2'd3; e_err = s & 16'hFFFC; e_tag = "R10";
            end else if (!t) begin
                e_ldt_sel = s; e_ldt_lo = lo; e_ldt_hi = hi; e_ldt_v = 1; e_tag = "R11";
            end else begin
                e_tr_sel = s; e_tr_lo = lo; e_tr_hi = hi | 32'h200; e_tr_v = 1; e_tag = "R12";
                if (!hi[9]) begin
                    e_nacc = 3;
                    e_addr[2] = a + 4; e_we[2] = 1;
                    e_wb_idx = 2*idx+1;
                    e_wb_data = hi | 32'h200;
                end
            end
        end
    endtask

    task automatic run_op(input bit p, input logic [1:0] c, input bit t,
                          input logic [15:0] s, input logic [15:0] lim);
        int cyc;
        string ctag, atag;
        model(p, c, t, s, lim);
        @(negedge clk);
        log_n = 0;
        prot_en = p; cpl = c; target = t; selector = s; table_limit = lim;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 300, "R14", "done seen", 32'(cyc), 32'd300);
        chk(fault_kind == e_fk, e_tag, "fault kind", 32'(fault_kind), 32'(e_fk));
        chk(fault_err == e_err, e_tag, "fault code", 32'(fault_err), 32'(e_err));
        ctag = (e_fk != 2'd0) ? "R13" : e_tag;
        chk(ldt_valid == e_ldt_v, ctag, "ldt valid", 32'(ldt_valid), 32'(e_ldt_v));
        chk(ldt_sel == e_ldt_sel, ctag, "ldt sel", 32'(ldt_sel), 32'(e_ldt_sel));
        chk(ldt_lo == e_ldt_lo, ctag, "ldt lo", ldt_lo, e_ldt_lo);
        chk(ldt_hi == e_ldt_hi, ctag, "ldt hi", ldt_hi, e_ldt_hi);
        chk(tr_valid == e_tr_v, ctag, "tr valid", 32'(tr_valid), 32'(e_tr_v));
        chk(tr_sel == e_tr_sel, ctag, "tr sel", 32'(tr_sel), 32'(e_tr_sel));
        chk(tr_lo == e_tr_lo, ctag, "tr lo", tr_lo, e_tr_lo);
        chk(tr_hi == e_tr_hi, ctag, "tr hi", tr_hi, e_tr_hi);
        atag = (e_nacc == 0) ? e_tag : "R7";
        chk(log_n == e_nacc, atag, "access count", 32'(log_n), 32'(e_nacc));
        for (int i = 0; i < e_nacc && i < log_n; i++) begin
            chk(log_addr[i] == e_addr[i], (i == 2) ? "R12" : "R7", "access addr",
                log_addr[i], e_addr[i]);
            chk(log_we[i] == e_we[i], (i == 2) ? "R12" : "R7", "access kind",
                32'(log_we[i]), 32'(e_we[i]));
        end
        if (e_nacc == 3)
            chk(dmem[e_wb_idx] == e_wb_data, "R12", "busy write-back", dmem[e_wb_idx], e_wb_data);
        @(negedge clk);
        chk(done == 1'b0, "R14", "done one cycle", 32'(done), 32'd0);
    endtask

    task automatic fill_table();
        logic [31:0] hi;
        logic [3:0] tys [6];
        tys = '{4'h1, 4'h2, 4'h3, 4'h9, 4'hB, 4'h0};
        for (int i = 0; i < NDESC; i++) begin
            hi = $urandom;
            hi[12] = ($urandom % 4 == 0);
            hi[11:8] = ($urandom % 6 == 5) ? 4'($urandom) : tys[$urandom % 5];
            hi[15] = ($urandom % 4 != 0);
            dmem[2*i]   = $urandom;
            dmem[2*i+1] = hi;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R14 watchdog expired: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] s, lim;
        logic [1:0] c;
        bit p, t;
        int idx;
        void'($urandom(32'd7321));
        fill_table();
        dmem[3]  = 32'h0040_8200; dmem[2]  = 32'h1234_FFFF; // idx1 LDT present
        dmem[5]  = 32'h0000_8900; dmem[4]  = 32'h5000_0067; // idx2 TSS32 avail
        dmem[7]  = 32'h0000_E100; dmem[6]  = 32'h6000_002B; // idx3 TSS16 avail
        dmem[9]  = 32'h0000_8B00; dmem[8]  = 32'h7000_0067; // idx4 TSS32 busy
        dmem[11] = 32'h0000_0200; dmem[10] = 32'h8000_0FFF; // idx5 LDT absent
        dmem[13] = 32'h00CF_9A00; dmem[12] = 32'h0000_FFFF; // idx6 code segment
        dmem[15] = 32'h0000_0900; dmem[14] = 32'h9000_0067; // idx7 TSS32 absent

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ldt_valid == 0 && tr_valid == 0, "R14", "reset valid", 32'({ldt_valid, tr_valid}), 32'd0);
        chk(done == 0 && busy == 0 && mem_req == 0, "R14", "reset idle",
            32'({done, busy, mem_req}), 32'd0);
        chk(fault_kind == 2'd0, "R14", "reset fault", 32'(fault_kind), 32'd0);

        run_op(0, 2'd0, 0, 16'h0008, FULLLIM);   // R1
        run_op(1, 2'd3, 1, 16'h0010, FULLLIM);   // R2
        run_op(1, 2'd0, 0, 16'h0008, FULLLIM);   // R11
        run_op(1, 2'd0, 0, 16'h0003, FULLLIM);   // R3
        run_op(1, 2'd0, 1, 16'h0002, FULLLIM);   // R4
        run_op(1, 2'd0, 0, 16'h000D, FULLLIM);   // R5
        run_op(1, 2'd0, 0, 16'h0008, 16'd15);    // R6 boundary accepted
        run_op(1, 2'd0, 0, 16'h0008, 16'd14);    // R6 one past
        run_op(1, 2'd0, 1, 16'h0010, FULLLIM);   // R12
        run_op(1, 2'd0, 1, 16'h0010, FULLLIM);   // R9 now busy
        run_op(1, 2'd0, 1, 16'h0019, FULLLIM);   // R12 16-bit task segment
        run_op(1, 2'd0, 1, 16'h0020, FULLLIM);   // R9 busy type
        run_op(1, 2'd0, 0, 16'h0010, FULLLIM);   // R8 task segment for LDT
        run_op(1, 2'd0, 1, 16'h0008, FULLLIM);   // R9 LDT for task register
        run_op(1, 2'd0, 0, 16'h0030, FULLLIM);   // R8 code segment
        run_op(1, 2'd0, 0, 16'h0028, FULLLIM);   // R10
        run_op(1, 2'd0, 1, 16'h0038, FULLLIM);   // R10

        for (int k = 0; k < 300; k++) begin
            if (k % 50 == 0) fill_table();
            p = ($urandom % 10 != 0);
            c = ($urandom % 6 == 0) ? 2'($urandom_range(3, 1)) : 2'd0;
            t = $urandom % 2;
            idx = $urandom % NDESC;
            s = {13'(idx), 1'($urandom % 8 == 0), 2'($urandom)};
            lim = ($urandom % 3 == 0) ? 16'($urandom % (NDESC * 8)) : FULLLIM;
            run_op(p, c, t, s, lim);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule